// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block models a single-clock static memory with four-beat bursts. It samples the address, write data, chip selects, burst strobes and write enables on each rising clock edge. Read results come back through a registered output stage. A burst opens with one of two start strobes. The address is registered at that point, and a two-bit beat counter then supplies the low address bits for the rest of the burst. The counter steps in one of two orders: XOR-style (interleaved) or wrap-around increment (linear). Later cycles of a burst need no strobe. They move to the next beat or repeat the current one, depending on the advance input.

There is one start strobe for a processor and one for a memory controller. The processor strobe counts only while the primary chip select is active, and the first cycle it opens is always a read. Write data enters on a separate input port. Read data leaves on `qOut`, and `qDrive` says when the bus would be driven. The bus keeps driving for one extra cycle after the access stream stops, then releases. An output-enable input and a sleep input take effect without waiting for the clock. While sleep is held high, every sampled cycle counts as a deselect.

Top module: `sram_burst_top`

## Requirements
- R1: The part is selected only when `cePrimN`=0, `ceHigh`=1 and `ceLowN`=0 on the edge of a start strobe. A start seen with any other combination ends the running burst and performs no access. After reset, `qDrive` is 0.
- R2: `procStartN`=0 is ignored while `cePrimN`=1, so a running burst continues as if no strobe were present. `ctrlStartN`=0 counts whatever `cePrimN` is.
- R3: The cycle in which `procStartN` opens a burst is a read, whatever the write inputs are. The cycles that follow may write.
- R4: Byte i is bits 8i+7..8i of the data. `writeAllN`=0 writes every byte. Otherwise, `byteWrEnN`=0 writes exactly the bytes whose `byteSelN` bit is 0. Any other input combination, including `byteWrEnN`=0 with all `byteSelN` bits at 1, makes the cycle a read.
- R5: With `orderSel`=1, beat k of a burst uses low address bits equal to the start low bits XOR k.
- R6: With `orderSel`=0, beat k uses the start low bits plus k, modulo 4. The upper address bits stay fixed for the whole burst.
- R7: In a burst cycle with no start strobe, `advanceN`=0 moves to the next beat and `advanceN`=1 repeats the current address. After beat 3 the count wraps to beat 0.
- R8: Data read in the cycle sampled at edge n appears on `qOut` with `qDrive`=1 after edge n+1.
- R9: A write sampled at edge n leaves `qDrive`=0 after edge n+1. The written bytes are visible to a read sampled at edge n+1 or later.
- R10: If no access is sampled at edge n and a read was sampled at edge n-1, `qDrive` stays 1 after edge n+1 and `qOut` keeps the old data. `qDrive` drops to 0 after edge n+2 unless a new read arrives.
- R11: `oeN`=1 forces `qDrive` to 0 at once. It does not disturb the pipeline, so the data reappears once `oeN` returns to 0.
- R12: While `sleep`=1, `qDrive` is 0 at once and every sampled cycle is a deselect that ends the running burst.
- R13: When both start strobes are low and `procStartN` is allowed to count, the processor strobe wins and the cycle is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control and output state |
| addrIn | input | ADDR_W | Start address of a burst |
| dIn | input | BYTES*8 | Write data |
| qOut | output | BYTES*8 | Registered read data |
| qDrive | output | 1 | High when the data bus would be driven |
| oeN | input | 1 | Asynchronous output enable, active low |
| cePrimN | input | 1 | Primary chip select, active low |
| ceHigh | input | 1 | Expansion chip select, active high |
| ceLowN | input | 1 | Expansion chip select, active low |
| procStartN | input | 1 | Processor burst start strobe, active low |
| ctrlStartN | input | 1 | Controller burst start strobe, active low |
| advanceN | input | 1 | Step to the next beat when low |
| orderSel | input | 1 | 1 = interleaved order, 0 = linear order |
| byteSelN | input | BYTES | Per-byte write selects, active low |
| byteWrEnN | input | 1 | Enables the per-byte selects, active low |
| writeAllN | input | 1 | Writes all bytes, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |

## Verification
The hardest case to reach is the one-cycle tail of R10. It needs a read, then a cycle with no access, with the output enable and sleep inputs both at the right levels when the pipeline reaches the pins. The stimulus reaches it by ending bursts with a start strobe whose chip selects do not match, and by ending them with a sleep pulse whose release lands exactly on the tail cycle. It also ends a burst with a processor strobe that is ignored and then a controller strobe with the primary select high, which separates R2 from R1. All expected values come from a reference model in the bench that tracks burst state and memory contents from the requirements.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  localparam int BEAT_BITS = 2;

  // Strobes passed from the control module to the datapath, one cycle after sampling
  typedef struct packed {
    logic rdGo;
    logic wrGo;
  } accCmd_t;

  // Low address bits of a given beat
  function automatic logic [BEAT_BITS-1:0] beatLow(
    input logic [BEAT_BITS-1:0] startLow,
    input logic [BEAT_BITS-1:0] beatIdx,
    input logic                 interleave
  );
    return interleave ? (startLow ^ beatIdx) : (startLow + beatIdx);
  endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              killEn,
  input  logic              advEn,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] accAddr,
  output logic              burstLive
);

  logic [ADDR_W-1:0]    baseQ;
  logic [BEAT_BITS-1:0] cntQ;
  logic [BEAT_BITS-1:0] cntNext;
  logic                 liveQ;

  always_comb begin
    cntNext = cntQ + {{(BEAT_BITS-1){1'b0}}, advEn};
    if (loadEn) begin
      accAddr = addrIn;
    end else begin
      accAddr = {baseQ[ADDR_W-1:BEAT_BITS],
                 beatLow(baseQ[BEAT_BITS-1:0], cntNext, interleave)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ <= 1'b0;
      baseQ <= '0;
      cntQ  <= '0;
    end else if (killEn) begin
      liveQ <= 1'b0;
    end else if (loadEn) begin
      liveQ <= 1'b1;
      baseQ <= addrIn;
      cntQ  <= '0;
    end else if (liveQ) begin
      cntQ  <= cntNext;
    end
  end

  assign burstLive = liveQ;

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cePrimN,
  input  logic              ceHigh,
  input  logic              ceLowN,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic [BYTES-1:0]  byteSelN,
  input  logic              byteWrEnN,
  input  logic              writeAllN,
  input  logic              sleep,
  output accCmd_t           cmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BYTES-1:0]  cmdMask
);

  logic              selOk;
  logic              procGo;
  logic              ctrlGo;
  logic              startAny;
  logic              loadEn;
  logic              killEn;
  logic              access;
  logic              isWr;
  logic              burstLive;
  logic [BYTES-1:0]  reqMask;
  logic [ADDR_W-1:0] seqAddr;
  accCmd_t           nextCmd;

  always_comb begin
    selOk    = !cePrimN && ceHigh && !ceLowN;
    procGo   = !procStartN && !cePrimN && !sleep;
    ctrlGo   = !ctrlStartN && !sleep && !procGo;
    startAny = procGo || ctrlGo;
    if (!writeAllN)      reqMask = '1;
    else if (!byteWrEnN) reqMask = ~byteSelN;
    else                 reqMask = '0;
    loadEn = startAny && selOk;
    killEn = sleep || (startAny && !selOk);
    access = loadEn || (!startAny && !sleep && burstLive);
    isWr   = access && !procGo && (reqMask != '0);
    nextCmd.rdGo = access && !isWr;
    nextCmd.wrGo = isWr;
  end

  sram_burst_seq #(
    .ADDR_W (ADDR_W)
  ) seq_i (
    .clk        (clk),
    .rstN       (rstN),
    .loadEn     (loadEn),
    .killEn     (killEn),
    .advEn      (!advanceN),
    .interleave (orderSel),
    .addrIn     (addrIn),
    .accAddr    (seqAddr),
    .burstLive  (burstLive)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd     <= '0;
      cmdAddr <= '0;
      cmdMask <= '0;
    end else begin
      cmd     <= nextCmd;
      cmdAddr <= seqAddr;
      cmdMask <= isWr ? reqMask : '0;
    end
  end

endmodule

// File: rtl/sram_burst_path.sv
module sram_burst_path
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  accCmd_t              cmd,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [BYTES-1:0]     cmdMask,
  input  logic [BYTES*8-1:0]   dIn,
  input  logic                 oeN,
  input  logic                 sleep,
  output logic [BYTES*8-1:0]   qOut,
  output logic                 qDrive,
  output logic                 drivePipe
);

  localparam int DW    = BYTES * 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] dHeld;
  logic [DW-1:0] qReg;
  logic          driveQ;
  logic          tailUsed;

  always_ff @(posedge clk) begin
    dHeld <= dIn;
    for (int b = 0; b < BYTES; b++) begin
      if (cmd.wrGo && cmdMask[b]) begin
        store[cmdAddr][b*8 +: 8] <= dHeld[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg     <= '0;
      driveQ   <= 1'b0;
      tailUsed <= 1'b0;
    end else if (cmd.rdGo) begin
      qReg     <= store[cmdAddr];
      driveQ   <= 1'b1;
      tailUsed <= 1'b0;
    end else if (!cmd.wrGo && driveQ && !tailUsed) begin
      tailUsed <= 1'b1;
    end else begin
      driveQ   <= 1'b0;
      tailUsed <= 1'b0;
    end
  end

  assign qOut      = qReg;
  assign qDrive    = driveQ && !oeN && !sleep;
  assign drivePipe = driveQ;

endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [BYTES*8-1:0]   dIn,
  output logic [BYTES*8-1:0]   qOut,
  output logic                 qDrive,
  input  logic                 oeN,
  input  logic                 cePrimN,
  input  logic                 ceHigh,
  input  logic                 ceLowN,
  input  logic                 procStartN,
  input  logic                 ctrlStartN,
  input  logic                 advanceN,
  input  logic                 orderSel,
  input  logic [BYTES-1:0]     byteSelN,
  input  logic                 byteWrEnN,
  input  logic                 writeAllN,
  input  logic                 sleep
);

  accCmd_t           cmd;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BYTES-1:0]  cmdMask;
  logic              drivePipe;

  sram_burst_ctrl #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .addrIn     (addrIn),
    .cePrimN    (cePrimN),
    .ceHigh     (ceHigh),
    .ceLowN     (ceLowN),
    .procStartN (procStartN),
    .ctrlStartN (ctrlStartN),
    .advanceN   (advanceN),
    .orderSel   (orderSel),
    .byteSelN   (byteSelN),
    .byteWrEnN  (byteWrEnN),
    .writeAllN  (writeAllN),
    .sleep      (sleep),
    .cmd        (cmd),
    .cmdAddr    (cmdAddr),
    .cmdMask    (cmdMask)
  );

  sram_burst_path #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .cmdAddr   (cmdAddr),
    .cmdMask   (cmdMask),
    .dIn       (dIn),
    .oeN       (oeN),
    .sleep     (sleep),
    .qOut      (qOut),
    .qDrive    (qDrive),
    .drivePipe (drivePipe)
  );

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk
  import sram_burst_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sleep,
  input logic    procStartN,
  input logic    cePrimN,
  input accCmd_t cmd,
  input logic    drivePipe
);

  // R8
  rd_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdGo |=> drivePipe);

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrGo |=> !drivePipe);

  // R10
  tail_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.rdGo && !cmd.wrGo && $past(!cmd.rdGo && !cmd.wrGo)) |=> !drivePipe);

  // R12
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (!cmd.rdGo && !cmd.wrGo));

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStartN && !cePrimN && !sleep) |=> !cmd.wrGo);

endmodule

bind sram_burst_top sram_burst_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sleep      (sleep),
  .procStartN (procStartN),
  .cePrimN    (cePrimN),
  .cmd        (cmd),
  .drivePipe  (drivePipe)
);

// File: tb/sram_burst_tb.sv
module sram_burst_top_tb_top;

  localparam int PERIOD = 10;
  localparam int AW     = 8;
  localparam int BY     = 4;
  localparam int DW     = BY * 8;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] d;
    logic procN, ctrlN, advN, gwN, bweN;
    logic [BY-1:0] bwN;
    logic ceN, ce2, ce2N, mode, sleep, oeN;
  } pinSet_t;

  typedef struct {
    int            due;
    logic          drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] qOut;
  logic qDrive;
  logic oeN = 1'b0, cePrimN = 1'b0, ceHigh = 1'b1, ceLowN = 1'b0;
  logic procStartN = 1'b1, ctrlStartN = 1'b1, advanceN = 1'b1, orderSel = 1'b1;
  logic [BY-1:0] byteSelN = '1;
  logic byteWrEnN = 1'b1, writeAllN = 1'b1, sleep = 1'b0;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit finished = 0;
  exp_t sbq[$];

  logic [DW-1:0] refMem [1 << AW];
  logic          mActive = 1'b0;
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  logic          prevRd = 1'b0;
  logic [DW-1:0] prevData = '0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  sram_burst_top #(.ADDR_W(AW), .BYTES(BY)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dIn(dIn), .qOut(qOut),
    .qDrive(qDrive), .oeN(oeN), .cePrimN(cePrimN), .ceHigh(ceHigh),
    .ceLowN(ceLowN), .procStartN(procStartN), .ctrlStartN(ctrlStartN),
    .advanceN(advanceN), .orderSel(orderSel), .byteSelN(byteSelN),
    .byteWrEnN(byteWrEnN), .writeAllN(writeAllN), .sleep(sleep)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic pinSet_t idleP();
    pinSet_t p;
    p.addr = '0; p.d = '0; p.procN = 1; p.ctrlN = 1; p.advN = 1;
    p.gwN = 1; p.bweN = 1; p.bwN = '1; p.ceN = 0; p.ce2 = 1; p.ce2N = 0;
    p.mode = 1; p.sleep = 0; p.oeN = 0;
    return p;
  endfunction

  // Driver: applies one cycle of pins and pushes the expected output item
  task automatic step(input pinSet_t p, input string tag);
    logic sel, pg, cg, rd, wr;
    logic [BY-1:0] msk;
    logic [AW-1:0] a;
    exp_t it;
    @(posedge clk);
    #(PERIOD/4);
    addrIn = p.addr; dIn = p.d; procStartN = p.procN; ctrlStartN = p.ctrlN;
    advanceN = p.advN; writeAllN = p.gwN; byteWrEnN = p.bweN; byteSelN = p.bwN;
    cePrimN = p.ceN; ceHigh = p.ce2; ceLowN = p.ce2N; orderSel = p.mode;
    sleep = p.sleep; oeN = p.oeN;
    sel = !p.ceN && p.ce2 && !p.ce2N;
    pg  = !p.procN && !p.ceN && !p.sleep;
    cg  = !p.ctrlN && !p.sleep && !pg;
    msk = !p.gwN ? '1 : (!p.bweN ? ~p.bwN : '0);
    rd = 0; wr = 0; a = '0;
    if (p.sleep) mActive = 0;
    else if (pg || cg) begin
      if (sel) begin
        mActive = 1; mBase = p.addr; mCnt = 0; a = p.addr;
        if (pg || msk == '0) rd = 1; else wr = 1;
      end else mActive = 0;
    end else if (mActive) begin
      mCnt = mCnt + {1'b0, !p.advN};
      a = {mBase[AW-1:2], p.mode ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt)};
      if (msk == '0) rd = 1; else wr = 1;
    end
    if (wr)
      for (int b = 0; b < BY; b++)
        if (msk[b]) refMem[a][b*8 +: 8] = p.d[b*8 +: 8];
    it.due = edgeCnt + 2;
    it.tag = tag;
    if (rd) begin
      it.drv = 1; it.data = refMem[a]; prevData = refMem[a];
    end else if (!wr && prevRd) begin
      it.drv = 1; it.data = prevData;
    end else begin
      it.drv = 0; it.data = prevData;
    end
    prevRd = rd;
    sbq.push_back(it);
  endtask

  // Monitor: pops items that are due and compares them with the ports
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= edgeCnt) begin
      exp_t it;
      logic expDrv;
      it = sbq.pop_front();
      expDrv = it.drv && !oeN && !sleep;
      chk(qDrive === expDrv, {it.tag, " drive"}, {31'b0, qDrive}, {31'b0, expDrv});
      if (expDrv) chk(qOut === it.data, {it.tag, " data"}, qOut, it.data);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    chk(0, "R8 watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    pinSet_t p;
    for (int i = 0; i < (1 << AW); i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk(qDrive === 1'b0, "R1 reset", {31'b0, qDrive}, 32'd0);
    rstN = 1'b1;

    // R6 R4 R9: linear write burst from 0x10, all bytes
    p = idleP(); p.mode = 0; p.ctrlN = 0; p.addr = 8'h10; p.gwN = 0; p.d = 32'hA000_0010;
    step(p, "R4 R9");
    for (int k = 1; k < 4; k++) begin
      p = idleP(); p.mode = 0; p.advN = 0; p.gwN = 0; p.d = 32'hA000_0010 + k;
      step(p, "R6 R9");
    end
    // R5: interleaved write burst from 0x21
    p = idleP(); p.ctrlN = 0; p.addr = 8'h21; p.gwN = 0; p.d = 32'hB000_0000;
    step(p, "R5 R9");
    for (int k = 1; k < 4; k++) begin
      p = idleP(); p.advN = 0; p.gwN = 0; p.d = 32'hB000_0000 + k;
      step(p, "R5 R9");
    end
    // R4: full write, then partial byte write, then read with selects but no enable
    p = idleP(); p.ctrlN = 0; p.addr = 8'h30; p.gwN = 0; p.d = 32'h1111_1111;
    step(p, "R4");
    p = idleP(); p.ctrlN = 0; p.addr = 8'h30; p.bweN = 0; p.bwN = 4'b1010; p.d = 32'h2222_2222;
    step(p, "R4");
    p = idleP(); p.ctrlN = 0; p.addr = 8'h30; p.bwN = 4'b0000; p.d = 32'h3333_3333;
    step(p, "R4 R8");
    p = idleP(); p.ctrlN = 0; p.addr = 8'h30; p.bweN = 0; p.bwN = 4'b1111;
    step(p, "R4");
    // R3: processor start with global write low reads; R5 order; R7 hold and wrap
    p = idleP(); p.procN = 0; p.addr = 8'h12; p.gwN = 0; p.d = 32'hDEAD_BEEF;
    step(p, "R3 R8");
    for (int k = 1; k < 4; k++) begin
      p = idleP(); p.advN = 0; step(p, "R5");
    end
    p = idleP(); step(p, "R7 hold");
    p = idleP(); p.advN = 0; step(p, "R7 wrap");
    // R6: linear read from 0x21 with one hold
    p = idleP(); p.mode = 0; p.ctrlN = 0; p.addr = 8'h21; step(p, "R6");
    p = idleP(); p.mode = 0; p.advN = 0; step(p, "R6");
    p = idleP(); p.mode = 0; step(p, "R7 hold");
    p = idleP(); p.mode = 0; p.advN = 0; step(p, "R6");
    p = idleP(); p.mode = 0; p.advN = 0; step(p, "R6");
    // R1 R10: deselect by expansion select, tail then release
    p = idleP(); p.ctrlN = 0; p.ce2 = 0; step(p, "R1 R10");
    p = idleP(); p.advN = 0; step(p, "R10");
    p = idleP(); p.advN = 0; step(p, "R1");
    p = idleP(); p.ctrlN = 0; p.ce2N = 1; p.addr = 8'h10; step(p, "R1");
    p = idleP(); step(p, "R1");
    // R2: ignored processor strobe, then controller strobe with primary select high
    p = idleP(); p.mode = 0; p.ctrlN = 0; p.addr = 8'h10; step(p, "R2");
    p = idleP(); p.mode = 0; p.procN = 0; p.ceN = 1; p.addr = 8'h30; p.advN = 0;
    step(p, "R2");
    p = idleP(); p.mode = 0; p.ctrlN = 0; p.ceN = 1; p.addr = 8'h30; step(p, "R2");
    p = idleP(); p.advN = 0; step(p, "R2 R10");
    p = idleP(); p.advN = 0; step(p, "R2");
    // R13: both strobes, processor wins, no write
    p = idleP(); p.procN = 0; p.ctrlN = 0; p.addr = 8'h20; p.gwN = 0; p.d = 32'h0BAD_0BAD;
    step(p, "R13");
    p = idleP(); p.ctrlN = 0; p.addr = 8'h20; step(p, "R13");
    // R11: output enable masks a read without losing it
    p = idleP(); p.ctrlN = 0; p.addr = 8'h13; step(p, "R11");
    p = idleP(); p.advN = 0; step(p, "R11");
    p = idleP(); p.advN = 0; p.oeN = 1; step(p, "R11");
    p = idleP(); p.advN = 0; step(p, "R11");
    // R12: sleep ends the burst and blanks the bus
    p = idleP(); p.advN = 0; p.sleep = 1; step(p, "R12");
    p = idleP(); p.advN = 0; p.sleep = 1; step(p, "R12");
    p = idleP(); p.advN = 0; step(p, "R12");
    p = idleP(); p.advN = 0; step(p, "R12");
    p = idleP(); p.advN = 0; step(p, "R12");
    for (int k = 0; k < 4; k++) begin
      p = idleP(); step(p, "R10");
    end
    repeat (4) @(posedge clk);
    summary();
  end

endmodule